// File: doc/BRIEF.md
# Store Queue Commit and Write-Back Engine

This block keeps the stores of an out-of-order core in program order, each with a sequence number, an access size, a ready-to-write flag and an in-flight flag. When the core names a commit bound, every resident store that is not yet ready and whose sequence number is at or below the bound becomes ready. Ready stores are handed to the data cache oldest first. At most `LANES` requests go out in a cycle, one per cache port. A ready store of size zero is retired on the spot, with no cache request.

The cache accepts all of the presented requests in a cycle or refuses all of them through a single ready line. After a refusal the block remembers that it is blocked and presents the same requests again until they are accepted. A completion from the cache frees the slot of an in-flight store. A squash bound discards every store younger than the bound, starting from the youngest end. A store-conditional that executes without fault becomes ready at once, without waiting for commit.

The block reports how many more memory operations the core may dispatch. This is the smaller of the load queue's free count and the store queue's free count, minus one reserved entry, and never less than zero. Slots are reclaimed from the oldest end, so a freed slot that sits behind an older occupied one is not counted until that older one leaves. Sequence numbers are assumed not to wrap while stores are resident, and `DEPTH` is a power of two.

Top module: `sq_commit_wb`

## Requirements
- R1: After reset the queue is empty, no cache request is presented, and `free_slots` equals min(`lq_free`, DEPTH) - 1.
- R2: Stores take slots in program order. `ins_slot` shows the slot the next insert uses, which is the slot after the youngest surviving store, and occupancy rises by one per insert.
- R3: A commit bound marks every resident, not-yet-ready store with sequence number at or below the bound as ready. Younger stores stay unready. The resulting requests appear in the cycle after the commit.
- R4: In a cycle at most LANES stores are requested. They fill lanes from lane 0 upward, oldest store on the lowest lane, with no gap between valid lanes.
- R5: A ready store of size zero is never requested. It leaves the queue at the edge that ends the cycle in which the oldest-first scan reaches it without using a lane. The scan stops once all lanes are used, so such a store waits behind a full set of lanes.
- R6: When `dc_ready` is low while requests are presented, the block holds exactly those requests, unchanged, in every later cycle until `dc_ready` is high. In that time it neither starts new requests nor retires zero-size stores.
- R7: A store accepted by the cache is never requested again. `dc_done_valid` with its slot removes it, and the slot is reclaimed at that edge when no older store remains.
- R8: `exe_valid` with `exe_cond` high and `exe_fault` low makes the named store ready without a commit. With `exe_fault` high, or `exe_cond` low, the store's state does not change.
- R9: A squash removes every store whose sequence number exceeds `flush_seq`. The removed stores, including ones already ready, are never requested, and their slots are reused by the next insert.
- R10: `free_slots` = max(min(`lq_free`, DEPTH - occupied) - 1, 0), where occupied counts the slots from the oldest remaining store to the youngest.
- R11: A commit in the same cycle that an older store is accepted by the cache takes effect. The newly ready store is requested in the next cycle, and the accepted one is not requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a store at the young end |
| ins_seq | input | SEQ_W | Sequence number of the inserted store |
| ins_size | input | SIZE_W | Access size in bytes, zero for a no-access store |
| ins_slot | output | IDX_W | Slot the insert goes to |
| exe_valid | input | 1 | Execute notification for one store |
| exe_slot | input | IDX_W | Slot of the executed store |
| exe_cond | input | 1 | Executed store is a store-conditional |
| exe_fault | input | 1 | Execution raised a fault |
| cmt_valid | input | 1 | Commit bound valid |
| cmt_seq | input | SEQ_W | Commit bound, inclusive |
| flush_valid | input | 1 | Squash bound valid |
| flush_seq | input | SEQ_W | Stores with a greater sequence number are discarded |
| dc_req_valid | output | LANES | Request valid per cache lane |
| dc_req_slot | output | LANES*IDX_W | Queue slot per lane |
| dc_req_seq | output | LANES*SEQ_W | Sequence number per lane |
| dc_req_size | output | LANES*SIZE_W | Access size per lane |
| dc_ready | input | 1 | Cache accepts every presented request this cycle |
| dc_done_valid | input | 1 | Cache finished one in-flight store |
| dc_done_slot | input | IDX_W | Slot of the finished store |
| lq_free | input | LQ_W | Free entries in the load queue |
| free_slots | output | FW | Operations the core may still dispatch |

## Verification
The collision that matters most is a commit bound arriving in the same cycle that the cache accepts an older store. The pending count then goes up and down at one edge, and the bench checks that the next cycle shows the younger store alone on lane 0. A second collision is a completion and an insert in the same edge while the cache refuses. Here the held request must stay identical, and the free count must reflect both the departed oldest slot and the new young one. Expected lanes, slots and free counts come from the bench's own slot arithmetic. The checker cross-checks the internal pending and in-flight counters against the entry flags every cycle.

// File: rtl/sq_pkg.sv
// Shared constants and helpers for the store queue write-back engine.
// Assumes callers pass non-negative counts.
package sq_pkg;

    localparam int SQ_DEF_DEPTH = 8;
    localparam int SQ_DEF_LANES = 2;

    // Smaller of two free counts, less one reserved entry, floored at zero.
    function automatic int min_less_one(input int a, input int b);
        int m;
        m = (a < b) ? a : b;
        return (m > 0) ? m - 1 : 0;
    endfunction

endpackage

// File: rtl/sq_wb_pick.sv
// Oldest-first write-back picker.
// Walks the occupied window from the oldest slot. Ready zero-size stores are
// flagged for retirement without a lane, and ready sized stores fill lanes
// from lane 0. The walk stops once every lane is used.
// Assumes DEPTH is a power of two so slot arithmetic wraps naturally.
module sq_wb_pick #(
    parameter int DEPTH = 8,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]       head,
    input  logic [PTR_W-1:0]       span,
    input  logic [DEPTH-1:0]       cand_nz,
    input  logic [DEPTH-1:0]       cand_z,
    output logic [LANES-1:0]       lane_vld,
    output logic [LANES*IDX_W-1:0] lane_slot,
    output logic [DEPTH-1:0]       zret
);

    // Age-ordered scan with a lane budget.
    always_comb begin
        int used;
        logic stop;
        logic [IDX_W-1:0] slot;
        used      = 0;
        stop      = 1'b0;
        lane_vld  = '0;
        lane_slot = '0;
        zret      = '0;
        for (int p = 0; p < DEPTH; p++) begin
            slot = head + IDX_W'(p);
            if (!stop && p < int'(span)) begin
                if (cand_z[slot]) begin
                    zret[slot] = 1'b1;
                end else if (cand_nz[slot]) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (k == used) begin
                            lane_vld[k] = 1'b1;
                            lane_slot[k*IDX_W +: IDX_W] = slot;
                        end
                    end
                    used = used + 1;
                    if (used == LANES) stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_head_adv.sv
// Oldest-end reclaim: counts the empty slots at the old end of the window,
// so the head pointer can jump past stores that already left.
// Assumes span never exceeds DEPTH.
module sq_head_adv #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] head,
    input  logic [PTR_W-1:0] span,
    input  logic [DEPTH-1:0] vld,
    output logic [PTR_W-1:0] lead
);

    // Count leading empty slots inside the window.
    always_comb begin
        logic go;
        logic [IDX_W-1:0] slot;
        go   = 1'b1;
        lead = '0;
        for (int p = 0; p < DEPTH; p++) begin
            slot = head + IDX_W'(p);
            if (go && p < int'(span) && !vld[slot]) lead = lead + 1'b1;
            else go = 1'b0;
        end
    end

endmodule

// File: rtl/sq_free_calc.sv
// Dispatch headroom: smaller of load-queue and store-queue free space, with one
// entry held back. Assumes occ never exceeds DEPTH.
module sq_free_calc #(
    parameter int DEPTH = 8,
    parameter int LQ_W  = 5,
    localparam int PTR_W = $clog2(DEPTH) + 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int FW    = (LQ_W > CNT_W) ? LQ_W : CNT_W
) (
    input  logic [PTR_W-1:0] occ,
    input  logic [LQ_W-1:0]  lq_free,
    output logic [FW-1:0]    free_slots
);
    import sq_pkg::*;

    // Combine both queues' free counts.
    always_comb begin
        free_slots = FW'(min_less_one(int'(lq_free), DEPTH - int'(occ)));
    end

endmodule

// File: rtl/sq_commit_wb.sv
// Store queue commit and write-back engine.
// Holds stores in a circular buffer in program order. Commit and
// store-conditional execution mark stores ready. Ready stores go to the cache
// oldest first under a per-cycle lane budget, zero-size ones retire in place,
// and completions and squashes free slots.
// Assumes: DEPTH a power of two; sequence numbers do not wrap while resident;
// no insert when full; squash never reaches a store already presented or sent.
module sq_commit_wb #(
    parameter int DEPTH  = sq_pkg::SQ_DEF_DEPTH,
    parameter int LANES  = sq_pkg::SQ_DEF_LANES,
    parameter int SEQ_W  = 8,
    parameter int SIZE_W = 4,
    parameter int LQ_W   = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int FW    = (LQ_W > CNT_W) ? LQ_W : CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic [SIZE_W-1:0]        ins_size,
    output logic [IDX_W-1:0]         ins_slot,
    input  logic                     exe_valid,
    input  logic [IDX_W-1:0]         exe_slot,
    input  logic                     exe_cond,
    input  logic                     exe_fault,
    input  logic                     cmt_valid,
    input  logic [SEQ_W-1:0]         cmt_seq,
    input  logic                     flush_valid,
    input  logic [SEQ_W-1:0]         flush_seq,
    output logic [LANES-1:0]         dc_req_valid,
    output logic [LANES*IDX_W-1:0]   dc_req_slot,
    output logic [LANES*SEQ_W-1:0]   dc_req_seq,
    output logic [LANES*SIZE_W-1:0]  dc_req_size,
    input  logic                     dc_ready,
    input  logic                     dc_done_valid,
    input  logic [IDX_W-1:0]         dc_done_slot,
    input  logic [LQ_W-1:0]          lq_free,
    output logic [FW-1:0]            free_slots
);

    // Entry state
    logic [DEPTH-1:0]  vld_q, rdy_q, snt_q;
    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [SIZE_W-1:0] size_q [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  pend_q, infl_q;
    logic              blk_q;
    logic [LANES-1:0]       hold_vld_q;
    logic [LANES*IDX_W-1:0] hold_slot_q;

    // Next-state and decode
    logic [PTR_W-1:0]  occ, tail_sq, tail_n, span_n, lead;
    logic [DEPTH-1:0]  inwin, kill, cset, eset, setm, zero;
    logic [DEPTH-1:0]  cand_nz, cand_z, zret_eff, snd, dmask;
    logic [DEPTH-1:0]  vld_n, rdy_n, snt_n;
    logic [LANES-1:0]       pk_vld, cur_vld;
    logic [LANES*IDX_W-1:0] pk_slot, cur_slot;
    logic [DEPTH-1:0]       pk_zret;
    logic [CNT_W-1:0]  pend_n, infl_n;

    assign occ = tail_q - head_q;

    // Per-slot decode of window, squash, commit and execute marks.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [IDX_W-1:0] off;
        assign off      = IDX_W'(s) - head_q[IDX_W-1:0];
        assign inwin[s] = {1'b0, off} < occ;
        assign kill[s]  = flush_valid && inwin[s] && (seq_q[s] > flush_seq);
        assign cset[s]  = cmt_valid && vld_q[s] && !rdy_q[s] && (seq_q[s] <= cmt_seq);
        assign eset[s]  = exe_valid && exe_cond && !exe_fault && (exe_slot == IDX_W'(s))
                          && vld_q[s] && !rdy_q[s];
        assign zero[s]  = (size_q[s] == '0);
        assign dmask[s] = dc_done_valid && (dc_done_slot == IDX_W'(s));
    end

    assign setm    = cset | eset;
    assign cand_nz = vld_q & rdy_q & ~snt_q & ~zero;
    assign cand_z  = vld_q & rdy_q & ~snt_q & zero;

    sq_wb_pick #(.DEPTH(DEPTH), .LANES(LANES)) u_pick (
        .head      (head_q[IDX_W-1:0]),
        .span      (occ),
        .cand_nz   (cand_nz),
        .cand_z    (cand_z),
        .lane_vld  (pk_vld),
        .lane_slot (pk_slot),
        .zret      (pk_zret)
    );

    // While blocked, the held selection is presented and nothing retires.
    assign cur_vld  = blk_q ? hold_vld_q  : pk_vld;
    assign cur_slot = blk_q ? hold_slot_q : pk_slot;
    assign zret_eff = blk_q ? '0 : pk_zret;

    // Per-lane request fields read from the entry table.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] ls;
        assign ls = cur_slot[k*IDX_W +: IDX_W];
        assign dc_req_valid[k]                = cur_vld[k];
        assign dc_req_slot[k*IDX_W +: IDX_W]  = ls;
        assign dc_req_seq[k*SEQ_W +: SEQ_W]   = seq_q[ls];
        assign dc_req_size[k*SIZE_W +: SIZE_W] = size_q[ls];
    end

    // Mark slots accepted by the cache this cycle.
    always_comb begin
        snd = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (dc_ready && cur_vld[k] && cur_slot[k*IDX_W +: IDX_W] == IDX_W'(s))
                    snd[s] = 1'b1;
            end
        end
    end

    // Tail after squash, then after insert.
    assign tail_sq  = tail_q - PTR_W'($countones(kill));
    assign ins_slot = tail_sq[IDX_W-1:0];
    assign tail_n   = tail_sq + PTR_W'(ins_valid);

    // Next entry flags.
    always_comb begin
        vld_n = vld_q & ~kill & ~zret_eff & ~dmask;
        rdy_n = (rdy_q | setm) & ~kill;
        snt_n = snt_q | snd;
        if (ins_valid) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (ins_slot == IDX_W'(s)) begin
                    vld_n[s] = 1'b1;
                    rdy_n[s] = 1'b0;
                    snt_n[s] = 1'b0;
                end
            end
        end
    end

    // Counter updates: newly ready, sent, retired, squashed, completed.
    assign pend_n = pend_q + CNT_W'($countones(setm & ~kill))
                           - CNT_W'($countones(snd))
                           - CNT_W'($countones(zret_eff))
                           - CNT_W'($countones(kill & vld_q & rdy_q & ~snt_q));
    assign infl_n = infl_q + CNT_W'($countones(snd)) - CNT_W'(dc_done_valid);

    assign span_n = tail_n - head_q;

    sq_head_adv #(.DEPTH(DEPTH)) u_head (
        .head (head_q[IDX_W-1:0]),
        .span (span_n),
        .vld  (vld_n),
        .lead (lead)
    );

    sq_free_calc #(.DEPTH(DEPTH), .LQ_W(LQ_W)) u_free (
        .occ        (occ),
        .lq_free    (lq_free),
        .free_slots (free_slots)
    );

    // Entry table and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rdy_q  <= '0;
            snt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            pend_q <= '0;
            infl_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                seq_q[s]  <= '0;
                size_q[s] <= '0;
            end
        end else begin
            vld_q  <= vld_n;
            rdy_q  <= rdy_n;
            snt_q  <= snt_n;
            head_q <= head_q + lead;
            tail_q <= tail_n;
            pend_q <= pend_n;
            infl_q <= infl_n;
            if (ins_valid) begin
                seq_q[ins_slot]  <= ins_seq;
                size_q[ins_slot] <= ins_size;
            end
        end
    end

    // Blocked flag and the held selection it replays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q       <= 1'b0;
            hold_vld_q  <= '0;
            hold_slot_q <= '0;
        end else begin
            blk_q <= (|cur_vld) && !dc_ready;
            if (!blk_q) begin
                hold_vld_q  <= pk_vld;
                hold_slot_q <= pk_slot;
            end
        end
    end

endmodule

// File: rtl/sq_commit_wb_chk.sv
// Property checker for the store queue write-back engine, bound to the top.
module sq_commit_wb_chk #(
    parameter int DEPTH  = 8,
    parameter int LANES  = 2,
    parameter int SIZE_W = 4,
    parameter int FW     = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        dc_req_valid,
    input logic [LANES*IDX_W-1:0]  dc_req_slot,
    input logic [LANES*SIZE_W-1:0] dc_req_size,
    input logic                    dc_ready,
    input logic                    dc_done_valid,
    input logic [IDX_W-1:0]        dc_done_slot,
    input logic [DEPTH-1:0]        vld_q,
    input logic [DEPTH-1:0]        rdy_q,
    input logic [DEPTH-1:0]        snt_q,
    input logic [CNT_W-1:0]        pend_q,
    input logic [CNT_W-1:0]        infl_q,
    input logic [FW-1:0]           free_slots
);

    // R3: pending counter agrees with ready, unsent entries.
    a_r3_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_q) == $countones(vld_q & rdy_q & ~snt_q));

    // R7: in-flight counter agrees with sent entries.
    a_r7_infl_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        int'(infl_q) == $countones(vld_q & snt_q));

    // R7: a completion names a store that is in flight.
    a_r7_done_inflight: assert property (@(posedge clk) disable iff (!rst_n)
        dc_done_valid |-> (vld_q[dc_done_slot] && snt_q[dc_done_slot]));

    // R6: a refused request set is presented again unchanged.
    a_r6_hold_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dc_req_valid) && !dc_ready) |=> ($stable(dc_req_valid) && $stable(dc_req_slot)));

    // R10: headroom never exceeds the queue less its reserved entry.
    a_r10_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_slots) <= DEPTH - 1);

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R5: zero-size stores never reach the cache.
        a_r5_no_zero_req: assert property (@(posedge clk) disable iff (!rst_n)
            dc_req_valid[k] |-> (dc_req_size[k*SIZE_W +: SIZE_W] != '0));
        // R7: a requested slot holds a resident store not yet accepted.
        a_r7_req_unsent: assert property (@(posedge clk) disable iff (!rst_n)
            dc_req_valid[k] |-> (vld_q[dc_req_slot[k*IDX_W +: IDX_W]]
                                 && !snt_q[dc_req_slot[k*IDX_W +: IDX_W]]));
        if (k > 0) begin : g_pack
            // R4: valid lanes are packed from lane 0.
            a_r4_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
                dc_req_valid[k] |-> dc_req_valid[k-1]);
        end
    end

endmodule

bind sq_commit_wb sq_commit_wb_chk #(
    .DEPTH(DEPTH), .LANES(LANES), .SIZE_W(SIZE_W), .FW(FW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .dc_req_valid(dc_req_valid), .dc_req_slot(dc_req_slot), .dc_req_size(dc_req_size),
    .dc_ready(dc_ready), .dc_done_valid(dc_done_valid), .dc_done_slot(dc_done_slot),
    .vld_q(vld_q), .rdy_q(rdy_q), .snt_q(snt_q),
    .pend_q(pend_q), .infl_q(infl_q), .free_slots(free_slots)
);

// File: tb/test_sq_commit_wb.sv
`timescale 1ns/1ps
module test_sq_commit_wb;
    localparam int DEPTH = 4, LANES = 2, SEQ_W = 8, SIZE_W = 4, LQ_W = 4;
    localparam int IDX_W = 2, FW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid = 0, exe_valid = 0, exe_cond = 0, exe_fault = 0;
    logic cmt_valid = 0, flush_valid = 0, dc_ready = 1, dc_done_valid = 0;
    logic [SEQ_W-1:0] ins_seq = 0, cmt_seq = 0, flush_seq = 0;
    logic [SIZE_W-1:0] ins_size = 0;
    logic [IDX_W-1:0] exe_slot = 0, dc_done_slot = 0, ins_slot;
    logic [LANES-1:0] dc_req_valid;
    logic [LANES*IDX_W-1:0] dc_req_slot;
    logic [LANES*SEQ_W-1:0] dc_req_seq;
    logic [LANES*SIZE_W-1:0] dc_req_size;
    logic [LQ_W-1:0] lq_free = 15;
    logic [FW-1:0] free_slots;

    int checks = 0, fails = 0, tb_tail = 0;
    logic finished = 0;

    always #4 clk = ~clk;

    sq_commit_wb #(.DEPTH(DEPTH), .LANES(LANES), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W), .LQ_W(LQ_W))
    i_sq_commit_wb (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_size(ins_size), .ins_slot(ins_slot),
        .exe_valid(exe_valid), .exe_slot(exe_slot), .exe_cond(exe_cond), .exe_fault(exe_fault),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .dc_req_valid(dc_req_valid), .dc_req_slot(dc_req_slot),
        .dc_req_seq(dc_req_seq), .dc_req_size(dc_req_size), .dc_ready(dc_ready),
        .dc_done_valid(dc_done_valid), .dc_done_slot(dc_done_slot),
        .lq_free(lq_free), .free_slots(free_slots)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock; pulse inputs drop 2 ns after the edge.
    task automatic cyc();
        @(posedge clk);
        #2;
        ins_valid = 0; exe_valid = 0; cmt_valid = 0; flush_valid = 0; dc_done_valid = 0;
    endtask

    task automatic ins(input int seq, input int size);
        ins_valid = 1; ins_seq = SEQ_W'(seq); ins_size = SIZE_W'(size);
        #1;
        chk(int'(ins_slot) == tb_tail, "R2 ins_slot", int'(ins_slot), tb_tail);
        cyc();
        tb_tail = (tb_tail + 1) % DEPTH;
    endtask

    task automatic chk_free(input int exp, input string req);
        chk(int'(free_slots) == exp, req, int'(free_slots), exp);
    endtask

    // Expect lane mask and slots for valid lanes.
    task automatic chk_req(input int mask, input int s0, input int s1, input string req);
        chk(int'(dc_req_valid) == mask, req, int'(dc_req_valid), mask);
        if (mask[0]) chk(int'(dc_req_slot[1:0]) == s0, req, int'(dc_req_slot[1:0]), s0);
        if (mask[1]) chk(int'(dc_req_slot[3:2]) == s1, req, int'(dc_req_slot[3:2]), s1);
    endtask

    task automatic done(input int slot);
        dc_done_valid = 1; dc_done_slot = IDX_W'(slot);
        cyc();
    endtask

    initial begin
        #160000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        chk_free(3, "R1 free after reset");
        chk_req(0, 0, 0, "R1 no request after reset");

        // R2, R10: fill in order
        ins(10, 4); chk_free(2, "R10 occ1");
        ins(11, 0); chk_free(1, "R10 occ2");
        ins(12, 2); chk_free(0, "R10 occ3");
        ins(13, 8); chk_free(0, "R10 full");
        chk_req(0, 0, 0, "R3 nothing ready before commit");

        // R3, R5: commit 11 -> slot0 requested, zero-size slot1 not
        cmt_valid = 1; cmt_seq = 11; cyc();
        chk_req(1, 0, 0, "R3 R5 commit to 11");
        chk(dc_req_seq[7:0] == 8'd10, "R3 seq on lane0", int'(dc_req_seq[7:0]), 10);
        cyc();
        chk_req(0, 0, 0, "R7 sent not re-requested");
        chk_free(0, "R7 in-flight holds slot");
        done(0);
        chk_free(1, "R5 R7 oldest two reclaimed");

        // R11: commit 13 in the cycle slot2 is accepted
        cmt_valid = 1; cmt_seq = 12; cyc();
        chk_req(1, 2, 0, "R11 older store presented");
        cmt_valid = 1; cmt_seq = 13; cyc();
        chk_req(1, 3, 0, "R11 younger store next cycle");

        // R6: refusal holds slot3; insert zero-size and complete slot2 meanwhile
        dc_ready = 0; cyc();
        chk_req(1, 3, 0, "R6 held after refusal");
        dc_done_valid = 1; dc_done_slot = 2;
        ins(14, 0);
        chk_req(1, 3, 0, "R6 held with done and insert");
        chk_free(1, "R6 R10 free after done and insert");
        cmt_valid = 1; cmt_seq = 14; cyc();
        chk_req(1, 3, 0, "R6 held after commit");
        chk_free(1, "R6 zero-size not retired while blocked");
        dc_ready = 1; cyc();
        chk_req(0, 0, 0, "R6 R7 unblocked, no re-request");
        cyc();
        chk_free(1, "R5 hole behind in-flight store");
        done(3);
        chk_free(3, "R7 queue drained");

        // R8: store-conditional readiness at execute
        ins(20, 4); ins(21, 4);
        exe_valid = 1; exe_slot = 2; exe_cond = 1; exe_fault = 0; cyc();
        chk_req(1, 2, 0, "R8 SC ready without commit");
        chk(dc_req_seq[7:0] == 8'd21, "R8 SC seq", int'(dc_req_seq[7:0]), 21);
        cyc();
        exe_valid = 1; exe_slot = 1; exe_cond = 1; exe_fault = 1; cyc();
        chk_req(0, 0, 0, "R8 faulting SC stays unready");
        exe_valid = 1; exe_slot = 1; exe_cond = 0; exe_fault = 0; cyc();
        chk_req(0, 0, 0, "R8 plain store execute no effect");
        cmt_valid = 1; cmt_seq = 20; cyc();
        chk_req(1, 1, 0, "R8 commit releases faulted store");
        cyc();
        done(1); done(2);
        chk_free(3, "R8 drained");

        // R9: squash younger than 30, including a ready SC
        ins(30, 4); ins(31, 4); ins(32, 4);
        chk_free(0, "R9 before squash");
        flush_valid = 1; flush_seq = 30;
        exe_valid = 1; exe_slot = 1; exe_cond = 1; exe_fault = 0; cyc();
        tb_tail = 0;
        chk_free(2, "R9 squash frees two");
        chk_req(0, 0, 0, "R9 squashed SC not requested");
        cmt_valid = 1; cmt_seq = 32; cyc();
        chk_req(1, 3, 0, "R9 only survivor requested");
        ins(33, 4);
        cyc();
        done(3);
        cmt_valid = 1; cmt_seq = 33; cyc();
        chk_req(1, 0, 0, "R9 reused slot carries new store");
        cyc();
        done(0);
        chk_free(3, "R9 drained");

        // R4, R5: lane budget and zero-size behind full lanes
        ins(40, 4); ins(41, 4); ins(42, 0); ins(43, 4);
        cmt_valid = 1; cmt_seq = 43; cyc();
        chk_req(3, 1, 2, "R4 two oldest on two lanes");
        cyc();
        chk_req(1, 0, 0, "R4 R5 zero retires, next store on lane0");
        chk_free(0, "R5 zero waits for lanes");
        cyc();
        done(1); chk_free(0, "R7 head to slot2");
        done(2); chk_free(2, "R5 R7 head past retired zero");
        done(0); chk_free(3, "R4 drained");

        // R10: sweep load-queue free count against occupancy
        for (int n = 0; n <= DEPTH; n++) begin
            for (int lq = 0; lq < 8; lq++) begin
                int m;
                lq_free = LQ_W'(lq);
                #1;
                m = (lq < DEPTH - n) ? lq : DEPTH - n;
                m = (m > 0) ? m - 1 : 0;
                chk_free(m, "R10 sweep");
            end
            lq_free = 15;
            if (n < DEPTH) ins(50 + n, 4);
        end
        flush_valid = 1; flush_seq = 49; cyc();
        chk_free(3, "R9 R10 squash all");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule